// File: doc/BRIEF.md
# Half-Group Memory Access Coalescer

This block sits between the address-generation stage of a 16-lane execution group and the memory request port. Each cycle it can accept one group of lane addresses, together with a per-lane active mask and a code for the word size every lane is using. It decides whether the whole group can be served as one contiguous segment access. If it can, it sends the segment as one burst request, or as two for the widest word size. If it cannot, it sends one request per active lane.

Requests leave through a valid/ready handshake that the memory side may stall. While a group is being issued the block holds `grp_ready` low. It takes a new group only in the cycle after the last request of the current group has been accepted. For each group that has at least one active lane, a one-cycle event pulse marks the group as merged or split. These pulses are meant to drive performance counters.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset `grp_ready` is 1, and `txn_valid`, `evt_coalesced` and `evt_split` are 0.
- R2: Word size code 2'b00 selects 4-byte words. If every active lane k addresses segment_base + 4*k, and segment_base is a multiple of 64, exactly one request is issued: address segment_base, `txn_bytes` = 64.
- R3: Word size code 2'b01 selects 8-byte words. If every active lane k addresses segment_base + 8*k, and segment_base is a multiple of 128, exactly one request is issued: address segment_base, `txn_bytes` = 128.
- R4: Word size code 2'b10 selects 16-byte words. If every active lane k addresses segment_base + 16*k, and segment_base is a multiple of 256, exactly two requests are issued, each with `txn_bytes` = 128: first at segment_base, then at segment_base + 128.
- R5: A segment base that is not aligned to the segment size (16 times the word size) prevents merging.
- R6: If any active lane addresses a word other than its own lane index within the segment, merging is prevented. Swapped lanes are one example.
- R7: Lanes whose mask bit is 0 are ignored. Their addresses do not affect the merge decision.
- R8: A group that is not merged issues one request per active lane, in ascending lane order, skipping inactive lanes. Each request carries that lane's address, and `txn_bytes` equals the word size in bytes.
- R9: Word size code 2'b11 selects 2-byte words. These are never merged, even when the addresses are sequential and aligned.
- R10: A group whose mask is all zeros is accepted, issues no request and raises neither event.
- R11: While a request waits with `txn_ready` low, `txn_valid`, `txn_addr` and `txn_bytes` hold steady. `grp_ready` stays low until the cycle after the group's last request is accepted.
- R12: In the cycle after a group with at least one active lane is accepted, exactly one of `evt_coalesced` and `evt_split` is 1, for one cycle only, and the first request of that group is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A group is offered |
| grp_ready | output | 1 | Block can accept a group |
| grp_addr | input | LANES*AW | Byte address of each lane; lane k at bits [k*AW +: AW] |
| grp_mask | input | LANES | Active lane mask |
| grp_wsize | input | 2 | Word size code (00=4B, 01=8B, 10=16B, 11=2B) |
| txn_valid | output | 1 | Request valid |
| txn_ready | input | 1 | Memory side accepts the request |
| txn_addr | output | AW | Request byte address |
| txn_bytes | output | 8 | Request length in bytes |
| evt_coalesced | output | 1 | One-cycle pulse: group merged |
| evt_split | output | 1 | One-cycle pulse: group split per lane |

## Verification
Most internal faults appear at the ports within one or two cycles of a group's acceptance.

- A wrong merge decision shows up in the cycle after acceptance: the event pulse that rises is the wrong one, and the first request's length is wrong.
- A corrupted pending-lane mask shows up one request later, as a skipped lane, a repeated lane or a lane issued out of order.
- A beat counter or busy flag that is stuck shows up right after the final handshake. The request count is then off by one, or `grp_ready` fails to return.

The bench compares the full request sequence of each group against an independent model, and stalls the handshake so that the holding behaviour is exposed.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    localparam logic [1:0] SZ_W4  = 2'b00;
    localparam logic [1:0] SZ_W8  = 2'b01;
    localparam logic [1:0] SZ_W16 = 2'b10;
    localparam logic [1:0] SZ_W2  = 2'b11;

    // log2 of the word size in bytes
    function automatic logic [3:0] word_shift(input logic [1:0] sz);
        case (sz)
            SZ_W4:   word_shift = 4'd2;
            SZ_W8:   word_shift = 4'd3;
            SZ_W16:  word_shift = 4'd4;
            default: word_shift = 4'd1;
        endcase
    endfunction

    function automatic logic [7:0] word_bytes(input logic [1:0] sz);
        word_bytes = 8'd1 << word_shift(sz);
    endfunction
endpackage

// File: rtl/hwc_lane_check.sv
module hwc_lane_check
    import hwc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 16,
    parameter int LANE  = 0
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    wsize,
    output logic [AW-1:0] seg_base,
    output logic          aligned
);
    localparam int LW = $clog2(LANES);

    logic [3:0]    sh;
    logic [5:0]    seg_sh;
    logic [AW-1:0] seg_mask;

    always_comb begin
        sh       = word_shift(wsize);
        // segment base this lane implies if it sits in its own slot
        seg_base = addr - (AW'(LANE) << sh);
        seg_sh   = 6'(LW) + {2'b00, sh};
        seg_mask = (AW'(1) << seg_sh) - AW'(1);
        aligned  = (seg_base & seg_mask) == '0;
    end
endmodule

// File: rtl/hwc_first_set.sv
module hwc_first_set #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer
    import hwc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grp_valid,
    output logic                grp_ready,
    input  logic [LANES*AW-1:0] grp_addr,
    input  logic [LANES-1:0]    grp_mask,
    input  logic [1:0]          grp_wsize,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_addr,
    output logic [7:0]          txn_bytes,
    output logic                evt_coalesced,
    output logic                evt_split
);
    localparam int IW = $clog2(LANES);
    localparam logic [AW-1:0] HALF_SEG = AW'(128);

    typedef struct packed {
        logic                      busy;
        logic                      coal;
        logic                      beat;
        logic [1:0]                wsize;
        logic [LANES-1:0]          pend;
        logic [AW-1:0]             base;
        logic [LANES-1:0][AW-1:0]  addrs;
        logic                      ev_c;
        logic                      ev_s;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0]  lane_base [LANES];
    logic [LANES-1:0] lane_ok;
    logic [IW-1:0]  in_first;
    logic           in_any;
    logic [IW-1:0]  cur_idx;
    logic           pend_any;
    logic           accept, fire, merge_ok;
    logic [LANES-1:0] pend_left;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        hwc_lane_check #(.AW(AW), .LANES(LANES), .LANE(k)) u_chk (
            .addr    (grp_addr[k*AW +: AW]),
            .wsize   (grp_wsize),
            .seg_base(lane_base[k]),
            .aligned (lane_ok[k])
        );
    end

    hwc_first_set #(.N(LANES)) u_in_first (
        .vec(grp_mask), .idx(in_first), .any(in_any)
    );

    hwc_first_set #(.N(LANES)) u_pend_first (
        .vec(st_q.pend), .idx(cur_idx), .any(pend_any)
    );

    always_comb begin
        merge_ok = in_any && (grp_wsize != SZ_W2);
        for (int k = 0; k < LANES; k++) begin
            if (grp_mask[k] && !(lane_ok[k] && lane_base[k] == lane_base[in_first]))
                merge_ok = 1'b0;
        end
    end

    assign accept    = grp_valid && !st_q.busy;
    assign fire      = st_q.busy && txn_ready;
    assign pend_left = st_q.pend & ~(LANES'(1) << cur_idx);

    always_comb begin
        st_d      = st_q;
        st_d.ev_c = 1'b0;
        st_d.ev_s = 1'b0;
        if (fire) begin
            if (st_q.coal) begin
                if (st_q.wsize == SZ_W16 && !st_q.beat) st_d.beat = 1'b1;
                else                                    st_d.busy = 1'b0;
            end else begin
                st_d.pend = pend_left;
                if (pend_left == '0) st_d.busy = 1'b0;
            end
        end
        if (accept) begin
            st_d.addrs = grp_addr;
            st_d.wsize = grp_wsize;
            st_d.pend  = grp_mask;
            st_d.base  = lane_base[in_first];
            st_d.coal  = merge_ok;
            st_d.beat  = 1'b0;
            st_d.busy  = in_any;
            st_d.ev_c  = merge_ok;
            st_d.ev_s  = in_any && !merge_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grp_ready     = !st_q.busy;
    assign txn_valid     = st_q.busy;
    assign txn_addr      = st_q.coal ? (st_q.beat ? st_q.base + HALF_SEG : st_q.base)
                                     : st_q.addrs[cur_idx];
    assign txn_bytes     = st_q.coal ? ((st_q.wsize == SZ_W4) ? 8'd64 : 8'd128)
                                     : word_bytes(st_q.wsize);
    assign evt_coalesced = st_q.ev_c;
    assign evt_split     = st_q.ev_s;

    // R11: stalled request holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_bytes));
    // R11: no new group while requests remain
    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !grp_ready);
    // R12: events exclusive
    p_evt_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_coalesced && evt_split));
    // R12: events are single-cycle
    p_evt_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_coalesced || evt_split) |=> !(evt_coalesced || evt_split));
    // R12: event coincides with first request
    p_evt_with_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_coalesced || evt_split) |-> txn_valid);
    // R8: a split group in flight always has a lane left
    p_split_work_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && evt_split |-> pend_any);
    // R2: request length is one of the legal sizes
    p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_bytes inside {8'd2, 8'd4, 8'd8, 8'd16, 8'd64, 8'd128}));
endmodule

// File: tb/hwc_coalescer_tb.sv
module hwc_coalescer_tb;
    localparam int AW    = 32;
    localparam int LANES = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                grp_valid = 1'b0;
    logic                grp_ready;
    logic [LANES*AW-1:0] grp_addr = '0;
    logic [LANES-1:0]    grp_mask = '0;
    logic [1:0]          grp_wsize = '0;
    logic                txn_valid;
    logic                txn_ready = 1'b0;
    logic [AW-1:0]       txn_addr;
    logic [7:0]          txn_bytes;
    logic                evt_coalesced, evt_split;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    hwc_coalescer #(.AW(AW), .LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_addr(grp_addr), .grp_mask(grp_mask), .grp_wsize(grp_wsize),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_bytes(txn_bytes),
        .evt_coalesced(evt_coalesced), .evt_split(evt_split)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drives one group and checks the full request sequence against a model.
    task automatic run_group(input logic [LANES*AW-1:0] a, input logic [LANES-1:0] m,
                             input logic [1:0] sz, input int stall, input string tag);
        int unsigned wb, sb, n;
        logic [AW-1:0] base, ex_a [LANES];
        logic [7:0]    ex_b [LANES];
        logic          merge;
        int            f;
        logic [AW-1:0] held;
        wb = (sz == 2'b00) ? 4 : (sz == 2'b01) ? 8 : (sz == 2'b10) ? 16 : 2;
        sb = 16 * wb;
        f = -1;
        for (int k = LANES - 1; k >= 0; k--) if (m[k]) f = k;
        merge = (f >= 0) && (sz != 2'b11);
        base = '0;
        if (f >= 0) base = a[f*AW +: AW] - AW'(f * wb);
        if (merge && (base % sb) != 0) merge = 1'b0;
        for (int k = 0; k < LANES; k++)
            if (m[k] && a[k*AW +: AW] != base + AW'(k * wb)) merge = 1'b0;
        n = 0;
        if (merge) begin
            ex_a[0] = base; ex_b[0] = (wb == 4) ? 8'd64 : 8'd128; n = 1;
            if (wb == 16) begin ex_a[1] = base + 128; ex_b[1] = 8'd128; n = 2; end
        end else begin
            for (int k = 0; k < LANES; k++)
                if (m[k]) begin ex_a[n] = a[k*AW +: AW]; ex_b[n] = 8'(wb); n++; end
        end

        @(negedge clk);
        grp_addr = a; grp_mask = m; grp_wsize = sz; grp_valid = 1'b1;
        txn_ready = (stall == 0);
        @(posedge clk);
        #1 grp_valid = 1'b0;
        @(negedge clk);
        check(evt_coalesced == (merge && n > 0), {tag, " R12 merged event"}, evt_coalesced, merge && n > 0);
        check(evt_split == (!merge && n > 0), {tag, " R12 split event"}, evt_split, !merge && n > 0);
        if (n == 0) begin
            check(!txn_valid, {tag, " R10 no request"}, txn_valid, 0);
            check(grp_ready, {tag, " R10 ready kept"}, grp_ready, 1);
            return;
        end
        if (stall > 0) begin
            held = txn_addr;
            for (int i = 0; i < stall; i++) begin
                check(txn_valid && txn_addr == held, {tag, " R11 held under stall"}, txn_addr, held);
                check(!grp_ready, {tag, " R11 ready low while busy"}, grp_ready, 0);
                @(negedge clk);
            end
            txn_ready = 1'b1;
        end
        for (int j = 0; j < int'(n); j++) begin
            check(txn_valid, {tag, " request valid"}, txn_valid, 1);
            check(txn_addr == ex_a[j], {tag, " request address"}, txn_addr, ex_a[j]);
            check(txn_bytes == ex_b[j], {tag, " request length"}, txn_bytes, ex_b[j]);
            if (j < int'(n) - 1)
                check(!grp_ready, {tag, " R11 ready low mid-group"}, grp_ready, 0);
            @(negedge clk);
            if (j == 0)
                check(!evt_coalesced && !evt_split, {tag, " R12 single pulse"},
                      {evt_coalesced, evt_split}, 0);
        end
        check(!txn_valid, {tag, " request count"}, txn_valid, 0);
        check(grp_ready, {tag, " R11 ready after last"}, grp_ready, 1);
        txn_ready = 1'b0;
    endtask

    function automatic logic [LANES*AW-1:0] seq(input logic [AW-1:0] b, input int step);
        logic [LANES*AW-1:0] r;
        for (int k = 0; k < LANES; k++) r[k*AW +: AW] = b + AW'(k * step);
        return r;
    endfunction

    task automatic t_reset();
        check(grp_ready && !txn_valid && !evt_coalesced && !evt_split, "R1 reset state",
              {grp_ready, txn_valid, evt_coalesced, evt_split}, 4'b1000);
    endtask

    task automatic t_w4_merge();  run_group(seq(32'h1000, 4), '1, 2'b00, 0, "R2"); endtask
    task automatic t_w8_merge();  run_group(seq(32'h2080, 8), '1, 2'b01, 0, "R3"); endtask
    task automatic t_w16_merge(); run_group(seq(32'h3100, 16), '1, 2'b10, 0, "R4"); endtask
    task automatic t_misalign();
        run_group(seq(32'h1020, 4), '1, 2'b00, 0, "R5 w4");
        run_group(seq(32'h2040, 8), 16'h0003, 2'b01, 0, "R5 w8");
    endtask
    task automatic t_swap();
        logic [LANES*AW-1:0] a;
        a = seq(32'h1000, 4);
        a[3*AW +: AW] = 32'h1010; a[4*AW +: AW] = 32'h100C;
        run_group(a, '1, 2'b00, 0, "R6");
    endtask
    task automatic t_inactive();
        logic [LANES*AW-1:0] a;
        a = seq(32'h4000, 4);
        for (int k = 0; k < LANES; k++) if (k % 8 < 4) a[k*AW +: AW] = 32'hDEAD0001 + k;
        run_group(a, 16'hF0F0, 2'b00, 0, "R7");
    endtask
    task automatic t_sparse_split();
        logic [LANES*AW-1:0] a;
        a = seq(32'h0500, 40);
        run_group(a, 16'h8421, 2'b01, 0, "R8");
    endtask
    task automatic t_w2();   run_group(seq(32'h6000, 2), 16'h0003, 2'b11, 0, "R9"); endtask
    task automatic t_empty(); run_group(seq(32'h7000, 4), '0, 2'b00, 0, "R10"); endtask
    task automatic t_stall();
        run_group(seq(32'h8000, 16), '1, 2'b10, 3, "R11 merged");
        run_group(seq(32'h9004, 4), 16'h0011, 2'b00, 2, "R11 split");
    endtask

    initial begin
        #(4 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_w4_merge();
        t_w8_merge();
        t_w16_merge();
        t_misalign();
        t_swap();
        t_inactive();
        t_sparse_split();
        t_w2();
        t_empty();
        t_stall();
        t_w4_merge();
        summary();
    end
endmodule